// File: doc/BRIEF.md
# Isolated Digital I/O Register Block with Change Interrupt

This block is the register-level core of a sixteen-output, sixteen-input digital I/O peripheral. A host reaches it through a small synchronous port with a 3-bit byte address, separate read and write strobes and 8-bit data. Two 8-bit output latches drive the output pins and can be read back. The sixteen input pins, in two banks of eight, pass through a synchronizer and an optional stability filter before software reads them or the change detector sees them.

Any level change on any input, in either direction, sets a sticky pending flag while interrupt generation is enabled, and a single level interrupt follows that flag. Several addresses act one way when read and another way when written. Reading the interrupt-control address turns interrupts on and writing it turns them off. Reading the filter-control address turns the filters on and writing it turns them off. Writing the low input address clears the pending interrupt.

Top module: `iso_io_regs`

## Requirements
- R1: After reset all output pins are 0, `irq` is 0, the status register (address 6) reads 0, interrupts are disabled and filters are inactive.
- R2: A write to address 0 replaces output pins 7:0 and a write to address 4 replaces output pins 15:8; a read of either address returns that bank's latch.
- R3: A read of address 1 returns the conditioned inputs 7:0 and a read of address 5 returns inputs 15:8.
- R4: A read of address 2 enables interrupt generation; a write of any value to address 2 disables it and drops `irq` at the next edge, while the pending flag is kept and reappears when interrupts are enabled again.
- R5: While interrupts are enabled, a rising or a falling edge on any conditioned input sets the pending flag; changes that occur while interrupts are disabled set nothing.
- R6: Status bit 0 is set by a change on inputs 7:0, bit 1 by a change on inputs 15:8, and bit 2 equals pending AND enabled; bits 7:3 read 0 and `irq` equals bit 2.
- R7: A write of any value to address 1 clears the pending flag and status bits 1:0, so `irq` is low at the next edge.
- R8: A read of address 3 activates filtering on all inputs, after which an input level held for fewer than 4 consecutive clocks never reaches the read data or the change detector; a write to address 3 deactivates filtering, after which a single-clock pulse is detected.
- R9: Writes to addresses 5 and 6 change neither the output pins nor the status register.
- R10: When a clear write to address 1 falls in the same cycle as a newly detected input change with interrupts enabled, the new change wins and the pending flag stays set.
- R11: Read data is registered and valid from the clock edge that samples the read strobe; addresses 2, 3 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Byte register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| out_pins | output | 16 | Output latch bits 15:0 |
| in_pins | input | 16 | Asynchronous input pins 15:0 |
| irq | output | 1 | Level interrupt, equal to status bit 2 |

## Verification
The clear write to address 1 and a freshly detected input change can land in the same clock, and the block must keep the new event rather than lose it. The bench drives an input toggle with filtering off and counts the synchronizer and filter register stages. It then places the clear write exactly in the cycle where the change detector sees the new level. It judges the outcome by `irq` staying high and by the status byte showing the bank of the new change. A clear write issued alone, in a quiet cycle, must drop `irq`, and that serves as the contrast.

// File: rtl/iso_io_pkg.sv
package iso_io_pkg;

   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_OUT_LO  = 3'd0,
      RA_IN_LO   = 3'd1,
      RA_IRQ_CTL = 3'd2,
      RA_FLT_CTL = 3'd3,
      RA_OUT_HI  = 3'd4,
      RA_IN_HI   = 3'd5,
      RA_STATUS  = 3'd6,
      RA_SPARE   = 3'd7
   } reg_addr_e;

   // status byte bit positions decoded by software
   localparam int unsigned ST_CHG_LO = 0;
   localparam int unsigned ST_CHG_HI = 1;
   localparam int unsigned ST_IRQ    = 2;

   localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/iso_in_cond.sv
module iso_in_cond #(
   parameter int unsigned WIDTH       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flt_on,
   input  logic [WIDTH-1:0] pin_async,
   output logic [WIDTH-1:0] pin_clean
);

   localparam int unsigned CNT_W   = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
   localparam int unsigned RUN_MAX = (FILT_LEN >= 2) ? FILT_LEN - 2 : 0;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [SYNC_STAGES-1:0] sync_q;
      logic                   smp;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async[b]};
      end
      assign smp = sync_q[SYNC_STAGES-1];

      if (FILT_LEN == 0) begin : g_nofilt
         logic val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= 1'b0;
            else        val_q <= smp;
         end
         assign pin_clean[b] = val_q;
      end else begin : g_filt
         logic             val_q;
         logic             last_q;
         logic [CNT_W-1:0] run_q;
         logic             run_ok;

         // run_q counts consecutive repeats of smp; the run length is run_q+2
         assign run_ok = (smp == last_q) && (run_q >= CNT_W'(RUN_MAX));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q  <= 1'b0;
               last_q <= 1'b0;
               run_q  <= '0;
            end else begin
               last_q <= smp;
               if (smp != last_q)               run_q <= '0;
               else if (run_q < CNT_W'(RUN_MAX)) run_q <= run_q + 1'b1;
               if (!flt_on)     val_q <= smp;
               else if (run_ok) val_q <= smp;
            end
         end
         assign pin_clean[b] = val_q;
      end
   end

endmodule

// File: rtl/iso_out_latch.sv
module iso_out_latch #(
   parameter int unsigned BANK_W    = 8,
   parameter int unsigned NUM_BANKS = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BANKS-1:0]        bank_we,
   input  logic [BANK_W-1:0]           wdata,
   output logic [NUM_BANKS*BANK_W-1:0] latch_q
);

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
      logic [BANK_W-1:0] bank_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          bank_q <= '0;
         else if (bank_we[k]) bank_q <= wdata;
      end
      assign latch_q[k*BANK_W +: BANK_W] = bank_q;
   end

endmodule

// File: rtl/iso_edge_irq.sv
module iso_edge_irq #(
   parameter int unsigned BANK_W    = 8,
   parameter int unsigned NUM_BANKS = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0] level,
   input  logic                        irq_en,
   input  logic                        clr,
   output logic [NUM_BANKS-1:0]        bank_flag,
   output logic                        pend_gated,
   output logic                        chg_any
);

   localparam int unsigned N = NUM_BANKS * BANK_W;

   logic [N-1:0]         prev_q;
   logic [N-1:0]         diff;
   logic [NUM_BANKS-1:0] bank_chg;
   logic [NUM_BANKS-1:0] flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   assign diff = level ^ prev_q;

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_flag
      assign bank_chg[k] = |diff[k*BANK_W +: BANK_W];
      // a new change outranks a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      flag_q[k] <= 1'b0;
         else if (bank_chg[k] && irq_en)  flag_q[k] <= 1'b1;
         else if (clr)                    flag_q[k] <= 1'b0;
      end
   end

   assign chg_any    = |bank_chg;
   assign bank_flag  = flag_q;
   assign pend_gated = (|flag_q) & irq_en;

endmodule

// File: rtl/iso_io_regs.sv
module iso_io_regs
   import iso_io_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BANK_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [2:0]              bus_addr,
   input  logic                    bus_rd,
   input  logic                    bus_wr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic [2*BANK_W-1:0]     out_pins,
   input  logic [2*BANK_W-1:0]     in_pins,
   output logic                    irq
);

   localparam int unsigned PINS = NUM_BANKS * BANK_W;

   if (BANK_W != DATA_W) begin : g_chk_w
      $error("iso_io_regs: BANK_W must equal DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("iso_io_regs: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN == 1) begin : g_chk_flt
      $error("iso_io_regs: FILT_LEN must be 0 or at least 2");
   end
   if (DATA_W < 3) begin : g_chk_st
      $error("iso_io_regs: status byte needs at least 3 bits");
   end

   reg_addr_e ra;
   logic      rd_go, wr_go;
   logic      irq_en_q, flt_on_q;
   logic      clr_pend;
   logic [NUM_BANKS-1:0] out_we;
   logic [PINS-1:0]      latch;
   logic [PINS-1:0]      clean;
   logic [NUM_BANKS-1:0] bank_flag;
   logic                 pend_gated;
   logic                 chg_any;
   logic [DATA_W-1:0]    status;
   logic [DATA_W-1:0]    rd_mux;

   assign ra    = reg_addr_e'(bus_addr);
   assign wr_go = bus_wr;
   assign rd_go = bus_rd & ~bus_wr;

   // control state: reads set, writes clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en_q <= 1'b0;
         flt_on_q <= 1'b0;
      end else begin
         if (wr_go && ra == RA_IRQ_CTL)      irq_en_q <= 1'b0;
         else if (rd_go && ra == RA_IRQ_CTL) irq_en_q <= 1'b1;
         if (wr_go && ra == RA_FLT_CTL)      flt_on_q <= 1'b0;
         else if (rd_go && ra == RA_FLT_CTL) flt_on_q <= 1'b1;
      end
   end

   assign clr_pend  = wr_go && (ra == RA_IN_LO);
   assign out_we[0] = wr_go && (ra == RA_OUT_LO);
   assign out_we[1] = wr_go && (ra == RA_OUT_HI);

   iso_out_latch #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .bank_we (out_we),
      .wdata   (bus_wdata),
      .latch_q (latch)
   );

   iso_in_cond #(.WIDTH(PINS), .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_in (
      .clk       (clk),
      .rst_n     (rst_n),
      .flt_on    (flt_on_q),
      .pin_async (in_pins),
      .pin_clean (clean)
   );

   iso_edge_irq #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .level      (clean),
      .irq_en     (irq_en_q),
      .clr        (clr_pend),
      .bank_flag  (bank_flag),
      .pend_gated (pend_gated),
      .chg_any    (chg_any)
   );

   always_comb begin
      status            = '0;
      status[ST_CHG_LO] = bank_flag[0];
      status[ST_CHG_HI] = bank_flag[1];
      status[ST_IRQ]    = pend_gated;
   end

   always_comb begin
      unique case (ra)
         RA_OUT_LO: rd_mux = latch[0 +: BANK_W];
         RA_OUT_HI: rd_mux = latch[BANK_W +: BANK_W];
         RA_IN_LO:  rd_mux = clean[0 +: BANK_W];
         RA_IN_HI:  rd_mux = clean[BANK_W +: BANK_W];
         RA_STATUS: rd_mux = status;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_go) bus_rdata <= rd_mux;
   end

   assign out_pins = latch;
   assign irq      = pend_gated;

endmodule

// File: rtl/iso_io_regs_chk.sv
module iso_io_regs_chk #(
   parameter int unsigned BANK_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [2:0]          bus_addr,
   input logic                bus_rd,
   input logic                bus_wr,
   input logic [BANK_W-1:0]   bus_wdata,
   input logic [2*BANK_W-1:0] out_pins,
   input logic                irq,
   input logic                irq_en,
   input logic                chg_any
);

   // R2
   out_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd0) |=> out_pins[BANK_W-1:0] == $past(bus_wdata));

   // R2
   out_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd4) |=> out_pins[2*BANK_W-1:BANK_W] == $past(bus_wdata));

   // R4
   irq_off_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd2) |=> !irq);

   // R6
   irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_en);

   // R7
   clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd1 && !chg_any) |=> !irq);

   // R9
   dead_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == 3'd5 || bus_addr == 3'd6)) |=> $stable(out_pins));

   // R10
   change_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd1 && chg_any && irq_en) |=> irq);

endmodule

bind iso_io_regs iso_io_regs_chk #(.BANK_W(BANK_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .out_pins  (out_pins),
   .irq       (irq),
   .irq_en    (irq_en_q),
   .chg_any   (chg_any)
);

// File: tb/tb_iso_io_regs.sv
module tb_iso_io_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] out_pins;
   logic [15:0] in_pins = '0;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   iso_io_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .out_pins(out_pins), .in_pins(in_pins), .irq(irq)
   );

   // {is_read, addr[2:0], data[7:0], expect[7:0]}
   localparam int NV = 12;
   localparam logic [19:0] VEC [NV] = '{
      {1'b0, 3'd0, 8'hA5, 8'h00},
      {1'b1, 3'd0, 8'h00, 8'hA5},
      {1'b0, 3'd4, 8'h3C, 8'h00},
      {1'b1, 3'd4, 8'h00, 8'h3C},
      {1'b0, 3'd5, 8'hFF, 8'h00},
      {1'b0, 3'd6, 8'hFF, 8'h00},
      {1'b1, 3'd4, 8'h00, 8'h3C},
      {1'b1, 3'd0, 8'h00, 8'hA5},
      {1'b1, 3'd6, 8'h00, 8'h00},
      {1'b1, 3'd7, 8'h00, 8'h00},
      {1'b0, 3'd0, 8'h5A, 8'h00},
      {1'b1, 3'd0, 8'h00, 8'h5A}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      chk("R1 out_pins", out_pins, 16'h0000);
      chk("R1 irq", {15'd0, irq}, 16'd0);
      rd(3'd6, v); chk("R1 status", {8'd0, v}, 16'h0000);

      // R2 R9 R11 vector table
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][19]) begin
            rd(VEC[i][18:16], v);
            chk("R2/R9/R11 table read", {8'd0, v}, {8'd0, VEC[i][7:0]});
         end else begin
            wr(VEC[i][18:16], VEC[i][15:8]);
         end
      end
      chk("R2 pins", out_pins, 16'h3C5A);
      wr(3'd6, 8'hFF);
      chk("R9 pins after status write", out_pins, 16'h3C5A);
      rd(3'd2, v); chk("R11 addr2 reads 0", {8'd0, v}, 16'h0000);
      wr(3'd2, 8'h00);

      // R3 and R5 (disabled: no pending)
      @(negedge clk); in_pins = 16'hC35A;
      idle(8);
      rd(3'd1, v); chk("R3 in lo", {8'd0, v}, 16'h005A);
      rd(3'd5, v); chk("R3 in hi", {8'd0, v}, 16'h00C3);
      rd(3'd6, v); chk("R5 disabled no pending", {8'd0, v}, 16'h0000);

      // R5 rising edge, R6 status
      rd(3'd2, v);
      @(negedge clk); in_pins[2] = 1'b1;
      idle(8);
      chk("R5 rising irq", {15'd0, irq}, 16'd1);
      rd(3'd6, v); chk("R6 status lo bank", {8'd0, v}, 16'h0005);
      wr(3'd1, 8'h00);
      chk("R7 irq cleared", {15'd0, irq}, 16'd0);
      rd(3'd6, v); chk("R7 status cleared", {8'd0, v}, 16'h0000);

      // R5 falling edge on bank 1
      @(negedge clk); in_pins[15] = 1'b0;
      idle(8);
      chk("R5 falling irq", {15'd0, irq}, 16'd1);
      rd(3'd6, v); chk("R6 status hi bank", {8'd0, v}, 16'h0006);

      // R4 disable keeps pending
      wr(3'd2, 8'h55);
      chk("R4 irq off", {15'd0, irq}, 16'd0);
      rd(3'd6, v); chk("R4 status while off", {8'd0, v}, 16'h0002);
      rd(3'd2, v);
      chk("R4 re-enable irq", {15'd0, irq}, 16'd1);
      wr(3'd1, 8'h00);

      // R8 filter on: 3-clock pulse ignored
      rd(3'd3, v);
      @(negedge clk); in_pins[0] = 1'b1;
      idle(3); in_pins[0] = 1'b0;
      idle(10);
      chk("R8 short pulse no irq", {15'd0, irq}, 16'd0);
      rd(3'd1, v); chk("R8 short pulse no data", {8'd0, v}, 16'h005E);
      @(negedge clk); in_pins[0] = 1'b1;
      idle(12);
      rd(3'd1, v); chk("R8 long level accepted", {8'd0, v}, 16'h005F);
      chk("R8 long level irq", {15'd0, irq}, 16'd1);
      wr(3'd1, 8'h00);
      wr(3'd3, 8'h00);
      @(negedge clk); in_pins[1] = 1'b0;
      @(negedge clk); in_pins[1] = 1'b1;
      idle(8);
      chk("R8 filter off pulse seen", {15'd0, irq}, 16'd1);
      wr(3'd1, 8'h00);
      chk("R7 quiet clear", {15'd0, irq}, 16'd0);

      // R10 clear and new change in the same cycle
      @(negedge clk); in_pins[9] = ~in_pins[9];
      @(posedge clk); @(posedge clk); @(posedge clk);
      @(negedge clk);
      bus_addr = 3'd1; bus_wdata = 8'h00; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      chk("R10 change wins irq", {15'd0, irq}, 16'd1);
      rd(3'd6, v); chk("R10 status", {8'd0, v}, 16'h0006);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule